// File: doc/BRIEF.md
# Time-Multiplexed RGB Panel Stream Transmitter

This block drives a 6-bit RGB video port on a passive-matrix colour panel of 160 x 128 pixels. It takes 18-bit pixels from a source over a valid/ready handshake and sends each one as three consecutive colour beats on a single 6-bit component bus: red first, then green, then blue. It also generates the dot clock, active-low horizontal and vertical sync, and a data-enable strobe.

A line is laid out in pixel units: sync, then back porch, then the active pixels, then front porch. A frame is laid out the same way in line units. Every porch and sync length is a parameter. The dot clock is divided from the system clock. All outputs change only on the system edge that drives the dot clock low, so they are stable around the rising edge where the panel samples them.

When the source has no pixel ready at the moment an active pixel begins, the block sends zeros for that pixel and sets a sticky underrun flag.

Top module: `rgb_seq_tx`

## Requirements
- R1: `dot_clk` is low for DOT_HALF system clocks and then high for DOT_HALF system clocks, repeating. It is low at reset and first rises DOT_HALF clocks after reset is released.
- R2: `rgb_bus`, `hsync_n`, `vsync_n` and `disp_en` change only on the system clock edge at which `dot_clk` falls.
- R3: Each active pixel takes three dot beats in this order: red `pix_data[17:12]`, then green `pix_data[11:6]`, then blue `pix_data[5:0]`. The component is carried on `rgb_bus[8:3]`.
- R4: `rgb_bus[2:0]` is always 0, and the whole of `rgb_bus` is 0 on every beat where `disp_en` is low.
- R5: Within a line of H_SYNC+H_BACK+H_ACTIVE+H_FRONT pixels, `hsync_n` is low for all three beats of each of the first H_SYNC pixels of every line, and high on all other beats.
- R6: Within a frame of V_SYNC+V_BACK+V_ACTIVE+V_FRONT lines, `vsync_n` is low for every beat of the first V_SYNC lines, and high on all other beats.
- R7: `disp_en` is high exactly on the beats of pixels H_SYNC+H_BACK through H_SYNC+H_BACK+H_ACTIVE-1 in lines V_SYNC+V_BACK through V_SYNC+V_BACK+V_ACTIVE-1. It is never high while either sync is low.
- R8: `pix_ready` is high for exactly one system clock per active pixel: the clock whose edge starts that pixel's red beat. A pixel is taken on that edge when `pix_valid` is high, and at no other time.
- R9: If `pix_valid` is low when `pix_ready` is high, that pixel is sent as zeros on all three beats and `underrun` goes high. `underrun` then stays high until reset, even after valid pixels resume.
- R10: During reset, `dot_clk`, `disp_en`, `rgb_bus`, `underrun` and `pix_ready` are 0 and both syncs are 1. The first beat after reset is beat 0 (red) of pixel 0 of line 0, so both syncs are low on that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 18 | Pixel: red [17:12], green [11:6], blue [5:0] |
| pix_valid | input | 1 | Source holds a pixel |
| pix_ready | output | 1 | Pixel taken on this clock edge when valid |
| dot_clk | output | 1 | Dot clock to the panel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | High on active pixel beats |
| rgb_bus | output | 9 | Component on [8:3], [2:0] held at zero |
| underrun | output | 1 | Sticky: an active pixel found no valid data |

## Verification
The bench uses a shrunken raster: 6 active pixels by 3 active lines, two-pixel horizontal sync, one-unit porches and vertical sync, and a dot half-period of two system clocks. With these values five whole frames fit in a few thousand cycles. That is enough to reach every line-wrap and frame-wrap boundary, the pixel at each edge of the active window, and the transitions between sync and porch on both axes. The middle frames drop valid at random, so underrun pixels land at line starts, line ends and mid-line. The last frame runs with valid held high, which shows that the flag stays set.

// File: rtl/rgbs_pkg.sv
package rgbs_pkg;

    localparam int COMP_W = 6;
    localparam int PAD_W  = 3;
    localparam int PIX_W  = 3 * COMP_W;
    localparam int BUS_W  = COMP_W + PAD_W;

    typedef enum logic [1:0] {
        BEAT_R = 2'd0,
        BEAT_G = 2'd1,
        BEAT_B = 2'd2
    } beat_e;

    // Decoded control for one dot beat
    typedef struct packed {
        logic  hs_n;
        logic  vs_n;
        logic  en;
        beat_e beat;
    } beat_ctl_t;

endpackage

// File: rtl/rgbs_dotclk.sv
module rgbs_dotclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic dot_clk,
    output logic tick
);
    localparam int PERIOD = 2 * HALF;
    localparam int PW     = $clog2(PERIOD);

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          clk_lvl;
    } dclk_t;

    dclk_t s_d, s_q;
    logic  wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.ph == PW'(PERIOD - 1));
        s_d.ph      = wrap ? '0 : s_q.ph + 1'b1;
        s_d.clk_lvl = (s_d.ph >= PW'(HALF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dot_clk = s_q.clk_lvl;
    // Edge that lowers the dot clock and advances the beat
    assign tick    = wrap;

endmodule

// File: rtl/rgbs_span.sv
module rgbs_span #(
    parameter int SYNC = 2,
    parameter int BACK = 4,
    parameter int ACT  = 160,
    parameter int W    = 8
) (
    input  logic [W-1:0] cnt,
    output logic         in_sync,
    output logic         in_act
);
    localparam int ACT_LO = SYNC + BACK;
    localparam int ACT_HI = SYNC + BACK + ACT;

    always_comb begin
        in_sync = (cnt < W'(SYNC));
        in_act  = (cnt >= W'(ACT_LO)) && (cnt < W'(ACT_HI));
    end

endmodule

// File: rtl/rgbs_raster.sv
module rgbs_raster
    import rgbs_pkg::*;
#(
    parameter int H_ACTIVE = 160,
    parameter int H_FRONT  = 4,
    parameter int H_SYNC   = 2,
    parameter int H_BACK   = 4,
    parameter int V_ACTIVE = 128,
    parameter int V_FRONT  = 2,
    parameter int V_SYNC   = 1,
    parameter int V_BACK   = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    output beat_ctl_t nxt_ctl
);
    localparam int H_TOT = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
    localparam int V_TOT = V_SYNC + V_BACK + V_ACTIVE + V_FRONT;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);

    typedef struct packed {
        beat_e         beat;
        logic [HW-1:0] px;
        logic [VW-1:0] ln;
    } pos_t;

    // Reset parks on the final beat of the frame so the first tick starts a frame
    localparam pos_t POS_RST = '{beat: BEAT_B, px: HW'(H_TOT - 1), ln: VW'(V_TOT - 1)};

    pos_t pos_d, pos_q, adv;
    logic h_sync, h_act, v_sync, v_act;

    always_comb begin
        adv = pos_q;
        if (pos_q.beat == BEAT_B) begin
            adv.beat = BEAT_R;
            if (pos_q.px == HW'(H_TOT - 1)) begin
                adv.px = '0;
                adv.ln = (pos_q.ln == VW'(V_TOT - 1)) ? '0 : pos_q.ln + 1'b1;
            end else begin
                adv.px = pos_q.px + 1'b1;
            end
        end else begin
            adv.beat = beat_e'(pos_q.beat + 2'd1);
        end
        pos_d = tick ? adv : pos_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_RST;
        end else begin
            pos_q <= pos_d;
        end
    end

    rgbs_span #(.SYNC(H_SYNC), .BACK(H_BACK), .ACT(H_ACTIVE), .W(HW)) u_hspan (
        .cnt     (adv.px),
        .in_sync (h_sync),
        .in_act  (h_act)
    );

    rgbs_span #(.SYNC(V_SYNC), .BACK(V_BACK), .ACT(V_ACTIVE), .W(VW)) u_vspan (
        .cnt     (adv.ln),
        .in_sync (v_sync),
        .in_act  (v_act)
    );

    always_comb begin
        nxt_ctl.hs_n = ~h_sync;
        nxt_ctl.vs_n = ~v_sync;
        nxt_ctl.en   = h_act & v_act;
        nxt_ctl.beat = adv.beat;
    end

endmodule

// File: rtl/rgbs_pixmux.sv
module rgbs_pixmux
    import rgbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  beat_e             beat,
    input  logic              en,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_valid,
    output logic [COMP_W-1:0] comp,
    output logic              underrun
);
    typedef struct packed {
        logic [PIX_W-1:0] hold;
        logic             under;
    } mux_t;

    mux_t m_d, m_q;
    logic [PIX_W-1:0] fresh, src;

    always_comb begin
        m_d   = m_q;
        fresh = pix_valid ? pix_data : '0;
        src   = start ? fresh : m_q.hold;
        if (start) begin
            m_d.hold  = fresh;
            m_d.under = m_q.under | ~pix_valid;
        end
        unique case (beat)
            BEAT_R:  comp = src[PIX_W-1 -: COMP_W];
            BEAT_G:  comp = src[2*COMP_W-1 -: COMP_W];
            BEAT_B:  comp = src[COMP_W-1:0];
            default: comp = '0;
        endcase
        if (!en) begin
            comp = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign underrun = m_q.under;

endmodule

// File: rtl/rgb_seq_tx.sv
module rgb_seq_tx
    import rgbs_pkg::*;
#(
    parameter int H_ACTIVE = 160,
    parameter int H_FRONT  = 4,
    parameter int H_SYNC   = 2,
    parameter int H_BACK   = 4,
    parameter int V_ACTIVE = 128,
    parameter int V_FRONT  = 2,
    parameter int V_SYNC   = 1,
    parameter int V_BACK   = 2,
    parameter int DOT_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [17:0] pix_data,
    input  logic        pix_valid,
    output logic        pix_ready,
    output logic        dot_clk,
    output logic        hsync_n,
    output logic        vsync_n,
    output logic        disp_en,
    output logic [8:0]  rgb_bus,
    output logic        underrun
);
    typedef struct packed {
        logic             hs_n;
        logic             vs_n;
        logic             en;
        logic [BUS_W-1:0] bus;
    } out_t;

    localparam out_t OUT_RST = '{hs_n: 1'b1, vs_n: 1'b1, en: 1'b0, bus: '0};

    logic              tick;
    logic              dot_lvl;
    logic              pix_start;
    beat_ctl_t         nxt_ctl;
    logic [COMP_W-1:0] nxt_comp;
    out_t              o_d, o_q;

    rgbs_dotclk #(.HALF(DOT_HALF)) u_dclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .dot_clk (dot_lvl),
        .tick    (tick)
    );

    rgbs_raster #(
        .H_ACTIVE (H_ACTIVE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC), .H_BACK (H_BACK),
        .V_ACTIVE (V_ACTIVE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC), .V_BACK (V_BACK)
    ) u_rast (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .nxt_ctl (nxt_ctl)
    );

    assign pix_start = tick && nxt_ctl.en && (nxt_ctl.beat == BEAT_R);

    rgbs_pixmux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pix_start),
        .beat      (nxt_ctl.beat),
        .en        (nxt_ctl.en),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .comp      (nxt_comp),
        .underrun  (underrun)
    );

    always_comb begin
        o_d = o_q;
        if (tick) begin
            o_d.hs_n = nxt_ctl.hs_n;
            o_d.vs_n = nxt_ctl.vs_n;
            o_d.en   = nxt_ctl.en;
            o_d.bus  = {nxt_comp, {PAD_W{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= OUT_RST;
        end else begin
            o_q <= o_d;
        end
    end

    assign pix_ready = pix_start;
    assign dot_clk   = dot_lvl;
    assign hsync_n   = o_q.hs_n;
    assign vsync_n   = o_q.vs_n;
    assign disp_en   = o_q.en;
    assign rgb_bus   = o_q.bus;

endmodule

// File: rtl/rgbs_checker.sv
module rgbs_checker #(
    parameter int HALF = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dot_clk,
    input logic       hsync_n,
    input logic       vsync_n,
    input logic       disp_en,
    input logic [8:0] rgb_bus,
    input logic       pix_ready,
    input logic       underrun
);
    logic prev_q;
    int   run_q;

    // Clocks since the dot clock last changed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            run_q  <= -1;
        end else begin
            prev_q <= dot_clk;
            run_q  <= (dot_clk != prev_q) ? 0 : run_q + 1;
        end
    end

    assert_dot_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_clk != prev_q) |-> (run_q == HALF - 1));

    assert_fall_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rgb_bus) || !$stable(hsync_n) || !$stable(vsync_n) || !$stable(disp_en))
        |-> $fell(dot_clk));

    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_bus[2:0] == 3'b000) && (disp_en || rgb_bus == 9'd0));

    assert_en_no_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (hsync_n && vsync_n));

    assert_ready_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |=> ($fell(dot_clk) && disp_en && !pix_ready));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

endmodule

bind rgb_seq_tx rgbs_checker #(.HALF(DOT_HALF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dot_clk   (dot_clk),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .disp_en   (disp_en),
    .rgb_bus   (rgb_bus),
    .pix_ready (pix_ready),
    .underrun  (underrun)
);

// File: tb/rgb_seq_tx_test.sv
module rgb_seq_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int HA = 6, HFP = 1, HS = 2, HBP = 1;
    localparam int VA = 3, VFP = 1, VS = 1, VBP = 1;
    localparam int HALF = 2;
    localparam int HT = HS + HBP + HA + HFP;
    localparam int VT = VS + VBP + VA + VFP;
    localparam int FT = 3 * HT * VT;
    localparam int FRAMES = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready, dot_clk, hsync_n, vsync_n, disp_en, underrun;
    logic [8:0]  rgb_bus;

    rgb_seq_tx #(
        .H_ACTIVE(HA), .H_FRONT(HFP), .H_SYNC(HS), .H_BACK(HBP),
        .V_ACTIVE(VA), .V_FRONT(VFP), .V_SYNC(VS), .V_BACK(VBP),
        .DOT_HALF(HALF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .dot_clk(dot_clk), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .disp_en(disp_en), .rgb_bus(rgb_bus), .underrun(underrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    int          beat_k = 0;
    int          run_len = 0;
    bit          first_run = 1'b1;
    bit          done = 1'b0;
    logic        prev_dot = 1'b0;
    logic [11:0] prev_out = 12'hC00;
    logic [17:0] pend[$];
    logic [17:0] cur_pix = '0;
    logic        exp_under = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (beat %0d)", req, act, exp, beat_k);
        end
    endtask

    function automatic logic [5:0] pick(input logic [17:0] p, input int b);
        if (b == 0) return p[17:12];
        if (b == 1) return p[11:6];
        return p[5:0];
    endfunction

    // Compare outputs at a rising dot edge with the raster position of beat_k
    task automatic check_beat();
        int pos, b, px, ln;
        bit e_en;
        logic [8:0] e_bus;
        pos = (beat_k == 0) ? FT - 1 : (beat_k - 1) % FT;
        b  = pos % 3;
        px = (pos / 3) % HT;
        ln = pos / (3 * HT);
        e_en = (px >= HS + HBP) && (px < HS + HBP + HA) && (ln >= VS + VBP) && (ln < VS + VBP + VA);
        if (e_en && b == 0) begin
            check(pend.size() == 1, "R8 one pixel taken per pixel start", pend.size(), 1);
            if (pend.size() > 0) cur_pix = pend.pop_front();
        end else begin
            check(pend.size() == 0, "R8 no take outside pixel start", pend.size(), 0);
        end
        e_bus = e_en ? {pick(cur_pix, b), 3'b000} : 9'd0;
        check(hsync_n == !(px < HS), (beat_k == 1) ? "R10 frame start hsync" : "R5 hsync",
              hsync_n, !(px < HS));
        check(vsync_n == !(ln < VS), "R6 vsync", vsync_n, !(ln < VS));
        check(disp_en == e_en, "R7 enable", disp_en, e_en);
        check(rgb_bus == e_bus, e_en ? "R3 component order" : "R4 idle bus zero", rgb_bus, e_bus);
        check(underrun == exp_under, "R9 underrun flag", underrun, exp_under);
    endtask

    task automatic step();
        logic [11:0] cur_out;
        int fr;
        cur_out = {hsync_n, vsync_n, disp_en, rgb_bus};
        if (cur_out != prev_out)
            check(prev_dot && !dot_clk, "R2 change only at dot fall", dot_clk, 0);
        prev_out = cur_out;
        if (dot_clk != prev_dot) begin
            if (!first_run) check(run_len == HALF, "R1 dot phase length", run_len, HALF);
            first_run = 1'b0;
            run_len = 1;
        end else begin
            run_len++;
        end
        if (dot_clk && !prev_dot) begin
            check_beat();
            beat_k++;
        end
        prev_dot = dot_clk;
        fr = beat_k / FT;
        pix_valid = (fr == 2 || fr == 3) ? ($urandom_range(0, 9) < 7) : 1'b1;
        pix_data  = 18'($urandom);
        if (pix_ready) begin
            pend.push_back(pix_valid ? pix_data : 18'd0);
            if (!pix_valid) exp_under = 1'b1;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(dot_clk == 1'b0, "R10 reset dot_clk", dot_clk, 0);
        check(hsync_n && vsync_n, "R10 reset syncs", {hsync_n, vsync_n}, 3);
        check(!disp_en && rgb_bus == 9'd0, "R10 reset enable and bus", {disp_en, rgb_bus}, 0);
        check(!underrun && !pix_ready, "R10 reset flags", {underrun, pix_ready}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < FRAMES * FT * 2 * HALF + 8; i++) begin
            @(negedge clk);
            step();
        end
        check(underrun == exp_under, "R9 flag held after valid resumed", underrun, exp_under);
        check(beat_k > FRAMES * FT - 2, "R1 beat count", beat_k, FRAMES * FT);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule